// File: doc/BRIEF.md
# Strided-Dependent Load Pair Detector

This block observes the loads retired by one warp context, one event per cycle. Each event reports the load's program counter, its effective address, the register it writes, the register that was added to a base to form its address, the value of that base, and the data the load returned. The block looks for a pattern that graph traversal kernels show: a "neighbor" load that walks an index array with a constant stride, followed by an "attribute" load whose address is a base value plus the index the neighbor load just returned.

Two tables do the work. A direct-mapped stride table, tagged by load PC, tracks each load's last address, last stride and a 2-bit confidence counter. A dependency table, indexed by destination register, remembers the PC and returned value of the most recent confidently strided load that wrote each register, and whether a later load was seen to consume that value as an address offset. When a confidently strided load arrives and its register entry is linked to an attribute load, the block emits one registered prefetch descriptor. The descriptor holds the next neighbor address, the attribute base value and both PCs, so a downstream issuer can fetch the next index and then the attribute it points to.

Top module: `ldp_pair_detector`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `desc_valid` is 0, and all table entries are empty, so no descriptor can follow until the training of R2 and R5 has happened again.
- R2: The stride table slot is selected by `ev_pc[5:2]` (16 slots) and tagged by `ev_pc[31:6]`. A load counts as strided only when its address delta from the previous load of the same PC is nonzero, equals the stored stride, and the counter was already at 2 (it is then 3, saturated). A constant nonzero stride therefore first counts as strided on the fifth load of a PC; a zero delta never does.
- R3: A delta that differs from the stored stride (or is zero) replaces the stored stride, clears the counter to 0, and clears any dependency link held for that load's destination register.
- R4: A strided load records its PC and its returned data in the dependency entry of its destination register; the link flag is kept only if the entry was already valid for the same PC.
- R5: A load whose `ev_idx_reg` names a valid entry, whose PC differs from that entry's PC, and whose address equals `ev_base_val` plus the entry's recorded data, links the entry to its own PC and base value. A load whose address does not match makes no link.
- R6: A strided load whose destination entry is valid for the same PC and linked produces, one cycle later, `desc_valid`=1 with `desc_next_addr` = its address plus its stride, `desc_base` and `desc_a_pc` from the link, and `desc_n_pc` = its PC; exactly one descriptor per such load.
- R7: A load of any PC that writes a register holding a valid entry and is not itself strided for that entry clears the entry, so a later strided load from the neighbor PC starts unlinked.
- R8: A load of a different PC mapping to the same stride slot replaces the slot and restarts training at counter 0; the next load of the evicted PC is then not strided.
- R9: A link stays in force across emissions; each strided load refreshes the recorded data used by R5.
- R10: `desc_valid` is 1 for a single cycle per qualifying event and is 0 on every cycle that follows a cycle with `ev_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A retired load event is present |
| ev_pc | input | 32 | Program counter of the load |
| ev_addr | input | 32 | Effective address of the load |
| ev_dst | input | 5 | Destination register of the load |
| ev_idx_reg | input | 5 | Register added to the base to form the address |
| ev_base_val | input | 32 | Value of the base operand of that add |
| ev_data | input | 32 | Value returned by the load |
| desc_valid | output | 1 | Prefetch descriptor present |
| desc_next_addr | output | 32 | Next neighbor load address |
| desc_base | output | 32 | Base value for the attribute address |
| desc_n_pc | output | 32 | PC of the neighbor load |
| desc_a_pc | output | 32 | PC of the attribute load |

## Verification
On every cycle the assertions check that a descriptor follows only a strided event of the same PC, that the two PCs of a descriptor differ, and that reset, idle cycles and stride mismatches are followed by no descriptor. Training length, link formation by value, clearing of links by mismatch, clobbering writes and slot eviction depend on multi-event histories, so only the bench's directed sequences and its reference-model comparison over a random mixture of neighbor, attribute and noise loads can show them.

// File: rtl/ldp_pkg.sv
package ldp_pkg;
  localparam int PC_W_DEF   = 32;
  localparam int ADDR_W_DEF = 32;
  localparam int REG_W_DEF  = 5;
  localparam int ST_IDX_DEF = 4;
  localparam int CONF_W_DEF = 2;

  typedef enum logic [1:0] {
    ST_MISS    = 2'd0,
    ST_TRAIN   = 2'd1,
    ST_STRIDED = 2'd2
  } st_verdict_e;
endpackage

// File: rtl/ldp_stride_table.sv
module ldp_stride_table
  import ldp_pkg::*;
#(
  parameter int PC_W   = PC_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int IDX_W  = ST_IDX_DEF,
  parameter int CONF_W = CONF_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [PC_W-1:0]   ev_pc,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              hit,
  output logic              match,
  output st_verdict_e       verdict,
  output logic [ADDR_W-1:0] delta
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};
  localparam logic [CONF_W-1:0] CONF_ARM = CONF_MAX - 1'b1;

  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q    [DEPTH];
  logic [ADDR_W-1:0] last_q   [DEPTH];
  logic [ADDR_W-1:0] stride_q [DEPTH];
  logic [CONF_W-1:0] conf_q   [DEPTH];

  logic [IDX_W-1:0]  slot;
  logic [TAG_W-1:0]  tag;

  assign slot = ev_pc[IDX_W+1:2];
  assign tag  = ev_pc[PC_W-1:IDX_W+2];

  always_comb begin
    hit   = vld_q[slot] && (tag_q[slot] == tag);
    delta = ev_addr - last_q[slot];
    match = hit && (delta == stride_q[slot]) && (delta != '0);
    if (!hit)
      verdict = ST_MISS;
    else if (match && (conf_q[slot] >= CONF_ARM))
      verdict = ST_STRIDED;
    else
      verdict = ST_TRAIN;
  end

  always_ff @(posedge clk) begin
    if (rst)
      vld_q <= '0;
    else if (ev_valid)
      vld_q[slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ev_valid) begin
      tag_q[slot]  <= tag;
      last_q[slot] <= ev_addr;
      if (!hit) begin
        stride_q[slot] <= '0;
        conf_q[slot]   <= '0;
      end else if (match) begin
        if (conf_q[slot] != CONF_MAX)
          conf_q[slot] <= conf_q[slot] + 1'b1;
      end else begin
        stride_q[slot] <= delta;
        conf_q[slot]   <= '0;
      end
    end
  end
endmodule

// File: rtl/ldp_dep_table.sv
module ldp_dep_table
  import ldp_pkg::*;
#(
  parameter int PC_W   = PC_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int REG_W  = REG_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [PC_W-1:0]   ev_pc,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [REG_W-1:0]  ev_dst,
  input  logic [REG_W-1:0]  ev_idx_reg,
  input  logic [ADDR_W-1:0] ev_base_val,
  input  logic [ADDR_W-1:0] ev_data,
  input  logic              strided,
  output logic              emit,
  output logic [ADDR_W-1:0] emit_base,
  output logic [PC_W-1:0]   emit_a_pc
);
  localparam int NREG = 1 << REG_W;

  logic [NREG-1:0]   vld_q;
  logic [NREG-1:0]   lnk_q;
  logic [PC_W-1:0]   npc_q   [NREG];
  logic [ADDR_W-1:0] nval_q  [NREG];
  logic [PC_W-1:0]   apc_q   [NREG];
  logic [ADDR_W-1:0] abase_q [NREG];

  logic same_owner;
  logic link_hit;
  logic link_take;

  always_comb begin
    same_owner = vld_q[ev_dst] && (npc_q[ev_dst] == ev_pc);
    emit       = ev_valid && strided && same_owner && lnk_q[ev_dst];
    emit_base  = abase_q[ev_dst];
    emit_a_pc  = apc_q[ev_dst];
    link_hit   = vld_q[ev_idx_reg] && (npc_q[ev_idx_reg] != ev_pc) &&
                 (ev_addr == ev_base_val + nval_q[ev_idx_reg]);
    link_take  = ev_valid && link_hit && (ev_idx_reg != ev_dst);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      lnk_q <= '0;
    end else if (ev_valid) begin
      if (strided) begin
        vld_q[ev_dst] <= 1'b1;
        lnk_q[ev_dst] <= same_owner && lnk_q[ev_dst];
      end else begin
        vld_q[ev_dst] <= 1'b0;
        lnk_q[ev_dst] <= 1'b0;
      end
      if (link_take)
        lnk_q[ev_idx_reg] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ev_valid && strided) begin
      npc_q[ev_dst]  <= ev_pc;
      nval_q[ev_dst] <= ev_data;
    end
  end

  always_ff @(posedge clk) begin
    if (link_take) begin
      apc_q[ev_idx_reg]   <= ev_pc;
      abase_q[ev_idx_reg] <= ev_base_val;
    end
  end
endmodule

// File: rtl/ldp_desc_out.sv
module ldp_desc_out
  import ldp_pkg::*;
#(
  parameter int PC_W   = PC_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [ADDR_W-1:0] base,
  input  logic [PC_W-1:0]   n_pc,
  input  logic [PC_W-1:0]   a_pc,
  output logic              desc_valid,
  output logic [ADDR_W-1:0] desc_next_addr,
  output logic [ADDR_W-1:0] desc_base,
  output logic [PC_W-1:0]   desc_n_pc,
  output logic [PC_W-1:0]   desc_a_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      desc_valid     <= 1'b0;
      desc_next_addr <= '0;
      desc_base      <= '0;
      desc_n_pc      <= '0;
      desc_a_pc      <= '0;
    end else begin
      desc_valid <= emit;
      if (emit) begin
        desc_next_addr <= cur_addr + stride;
        desc_base      <= base;
        desc_n_pc      <= n_pc;
        desc_a_pc      <= a_pc;
      end
    end
  end
endmodule

// File: rtl/ldp_pair_detector.sv
module ldp_pair_detector
  import ldp_pkg::*;
#(
  parameter int PC_W   = PC_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int REG_W  = REG_W_DEF,
  parameter int ST_IDX = ST_IDX_DEF,
  parameter int CONF_W = CONF_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [PC_W-1:0]   ev_pc,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [REG_W-1:0]  ev_dst,
  input  logic [REG_W-1:0]  ev_idx_reg,
  input  logic [ADDR_W-1:0] ev_base_val,
  input  logic [ADDR_W-1:0] ev_data,
  output logic              desc_valid,
  output logic [ADDR_W-1:0] desc_next_addr,
  output logic [ADDR_W-1:0] desc_base,
  output logic [PC_W-1:0]   desc_n_pc,
  output logic [PC_W-1:0]   desc_a_pc
);
  logic              st_hit;
  logic              st_match;
  st_verdict_e       st_verdict;
  logic [ADDR_W-1:0] st_delta;
  logic              st_strided;
  logic              dep_emit;
  logic [ADDR_W-1:0] dep_base;
  logic [PC_W-1:0]   dep_a_pc;

  ldp_stride_table #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(ST_IDX), .CONF_W(CONF_W)
  ) u_stride (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_pc(ev_pc),
    .ev_addr(ev_addr), .hit(st_hit), .match(st_match),
    .verdict(st_verdict), .delta(st_delta)
  );

  assign st_strided = ev_valid && (st_verdict == ST_STRIDED);

  ldp_dep_table #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
  ) u_dep (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_pc(ev_pc),
    .ev_addr(ev_addr), .ev_dst(ev_dst), .ev_idx_reg(ev_idx_reg),
    .ev_base_val(ev_base_val), .ev_data(ev_data), .strided(st_strided),
    .emit(dep_emit), .emit_base(dep_base), .emit_a_pc(dep_a_pc)
  );

  ldp_desc_out #(
    .PC_W(PC_W), .ADDR_W(ADDR_W)
  ) u_out (
    .clk(clk), .rst(rst), .emit(dep_emit), .cur_addr(ev_addr),
    .stride(st_delta), .base(dep_base), .n_pc(ev_pc), .a_pc(dep_a_pc),
    .desc_valid(desc_valid), .desc_next_addr(desc_next_addr),
    .desc_base(desc_base), .desc_n_pc(desc_n_pc), .desc_a_pc(desc_a_pc)
  );
endmodule

// File: rtl/ldp_pair_detector_chk.sv
module ldp_pair_detector_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            ev_valid,
  input logic [PC_W-1:0] ev_pc,
  input logic            st_hit,
  input logic            st_match,
  input logic            st_strided,
  input logic            desc_valid,
  input logic [PC_W-1:0] desc_n_pc,
  input logic [PC_W-1:0] desc_a_pc
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !desc_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> !desc_valid);

  // R2
  strided_gate_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> $past(st_strided));

  // R3
  mismatch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && st_hit && !st_match) |=> !desc_valid);

  // R6
  npc_source_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> (desc_n_pc == $past(ev_pc)));

  // R5
  pc_pair_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> (desc_n_pc != desc_a_pc));
endmodule

bind ldp_pair_detector ldp_pair_detector_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_pc(ev_pc),
  .st_hit(st_hit), .st_match(st_match), .st_strided(st_strided),
  .desc_valid(desc_valid), .desc_n_pc(desc_n_pc), .desc_a_pc(desc_a_pc)
);

// File: tb/sim_ldp_pair_detector.sv
module sim_ldp_pair_detector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [31:0] ev_pc = '0;
  logic [31:0] ev_addr = '0;
  logic [4:0]  ev_dst = '0;
  logic [4:0]  ev_idx_reg = '0;
  logic [31:0] ev_base_val = '0;
  logic [31:0] ev_data = '0;
  logic        desc_valid;
  logic [31:0] desc_next_addr, desc_base, desc_n_pc, desc_a_pc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ldp_pair_detector u0 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_pc(ev_pc),
    .ev_addr(ev_addr), .ev_dst(ev_dst), .ev_idx_reg(ev_idx_reg),
    .ev_base_val(ev_base_val), .ev_data(ev_data),
    .desc_valid(desc_valid), .desc_next_addr(desc_next_addr),
    .desc_base(desc_base), .desc_n_pc(desc_n_pc), .desc_a_pc(desc_a_pc)
  );

  // reference model built from the requirements
  bit          m_sv [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_last [16];
  logic [31:0] m_str [16];
  int          m_conf [16];
  bit          d_v [32];
  bit          d_l [32];
  logic [31:0] d_npc [32];
  logic [31:0] d_val [32];
  logic [31:0] d_apc [32];
  logic [31:0] d_base [32];

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_sv[i] = 1'b0;
    for (int i = 0; i < 32; i++) begin d_v[i] = 1'b0; d_l[i] = 1'b0; end
  endtask

  task automatic model_step(input logic [31:0] pc, addr, input logic [4:0] dst, idx,
                            input logic [31:0] base, data,
                            output bit ev, output logic [31:0] en, eb, ea);
    int s;
    bit hit, mt, str, own, lk;
    logic [31:0] dl;
    s = int'(pc[5:2]);
    hit = m_sv[s] && m_tag[s] == pc[31:6];
    dl = addr - m_last[s];
    mt = hit && dl == m_str[s] && dl != 0;
    str = mt && m_conf[s] >= 2;
    own = d_v[dst] && d_npc[dst] == pc;
    ev = str && own && d_l[dst];
    en = addr + dl; eb = d_base[dst]; ea = d_apc[dst];
    lk = d_v[idx] && d_npc[idx] != pc && addr == base + d_val[idx] && idx != dst;
    m_sv[s] = 1'b1; m_tag[s] = pc[31:6]; m_last[s] = addr;
    if (!hit) begin m_str[s] = 0; m_conf[s] = 0; end
    else if (mt) begin if (m_conf[s] < 3) m_conf[s]++; end
    else begin m_str[s] = dl; m_conf[s] = 0; end
    if (str) begin
      d_l[dst] = own && d_l[dst]; d_v[dst] = 1'b1; d_npc[dst] = pc; d_val[dst] = data;
    end else begin
      d_v[dst] = 1'b0; d_l[dst] = 1'b0;
    end
    if (lk) begin d_l[idx] = 1'b1; d_apc[idx] = pc; d_base[idx] = base; end
  endtask

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic issue(input logic [31:0] pc, addr, input logic [4:0] dst, idx,
                       input logic [31:0] base, data, input string req);
    bit ev;
    logic [31:0] en, eb, ea;
    model_step(pc, addr, dst, idx, base, data, ev, en, eb, ea);
    ev_valid = 1'b1; ev_pc = pc; ev_addr = addr; ev_dst = dst;
    ev_idx_reg = idx; ev_base_val = base; ev_data = data;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    check(desc_valid == ev && (!ev || (desc_next_addr == en && desc_base == eb &&
          desc_n_pc == pc && desc_a_pc == ea)), req,
          $sformatf("valid=%0b next=%h base=%h npc=%h apc=%h exp valid=%0b next=%h base=%h npc=%h apc=%h",
                    desc_valid, desc_next_addr, desc_base, desc_n_pc, desc_a_pc,
                    ev, en, eb, pc, ea));
  endtask

  task automatic expect_desc(input bit v, input logic [31:0] nxt, input string req);
    check(desc_valid == v && (!v || desc_next_addr == nxt), req,
          $sformatf("valid=%0b next=%h exp valid=%0b next=%h", desc_valid, desc_next_addr, v, nxt));
  endtask

  task automatic idle();
    ev_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(desc_valid == 1'b0, "R10", $sformatf("valid=%0b exp 0", desc_valid));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] na [2];
    logic [31:0] nd [2];
    int unsigned seed;
    seed = $urandom(32'd4321);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(desc_valid == 1'b0, "R1", $sformatf("valid=%0b exp 0", desc_valid));

    // R2: training over five loads of stride 4
    for (int i = 0; i < 4; i++) begin
      issue(32'h100, 32'h1000 + 4*i, 5'd2, 5'd1, 0, 5 + i, "R2");
      expect_desc(0, 0, "R2");
    end
    issue(32'h100, 32'h1010, 5'd2, 5'd1, 0, 9, "R4");
    // R5: link by value, R6: emission
    issue(32'h108, 32'h8009, 5'd4, 5'd2, 32'h8000, 1, "R5");
    issue(32'h100, 32'h1014, 5'd2, 5'd1, 0, 3, "R6");
    expect_desc(1, 32'h1018, "R6");
    check(desc_base == 32'h8000 && desc_a_pc == 32'h108, "R6",
          $sformatf("base=%h apc=%h exp 8000 108", desc_base, desc_a_pc));
    idle();
    issue(32'h100, 32'h1018, 5'd2, 5'd1, 0, 4, "R9");
    expect_desc(1, 32'h101C, "R9");
    // R3: mismatch clears the link
    issue(32'h100, 32'h1024, 5'd2, 5'd1, 0, 4, "R3");
    expect_desc(0, 0, "R3");
    issue(32'h100, 32'h1028, 5'd2, 5'd1, 0, 4, "R3");
    issue(32'h100, 32'h102C, 5'd2, 5'd1, 0, 4, "R3");
    issue(32'h100, 32'h1030, 5'd2, 5'd1, 0, 4, "R3");
    issue(32'h100, 32'h1034, 5'd2, 5'd1, 0, 32'h20, "R3");
    expect_desc(0, 0, "R3");
    // R5: wrong address makes no link
    issue(32'h108, 32'h8021, 5'd4, 5'd2, 32'h8000, 1, "R5");
    issue(32'h100, 32'h1038, 5'd2, 5'd1, 0, 32'h30, "R5");
    expect_desc(0, 0, "R5");
    issue(32'h108, 32'h8030, 5'd4, 5'd2, 32'h8000, 1, "R5");
    issue(32'h100, 32'h103C, 5'd2, 5'd1, 0, 32'h31, "R5");
    expect_desc(1, 32'h1040, "R5");
    // R7: clobber of the register by another PC
    issue(32'h30C, 32'h5000, 5'd2, 5'd0, 0, 7, "R7");
    issue(32'h100, 32'h1040, 5'd2, 5'd1, 0, 32'h32, "R7");
    expect_desc(0, 0, "R7");
    issue(32'h108, 32'h8032, 5'd4, 5'd2, 32'h8000, 1, "R7");
    // R8: alias eviction restarts training
    issue(32'h140, 32'h9000, 5'd9, 5'd0, 0, 0, "R8");
    issue(32'h100, 32'h1044, 5'd2, 5'd1, 0, 32'h33, "R8");
    expect_desc(0, 0, "R8");
    // R2: zero delta never strided
    for (int i = 0; i < 6; i++) issue(32'h20C, 32'h7000, 5'd12, 5'd0, 0, 1, "R2");
    issue(32'h214, 32'h8001, 5'd13, 5'd12, 32'h8000, 0, "R2");
    issue(32'h20C, 32'h7000, 5'd12, 5'd0, 0, 1, "R2");
    expect_desc(0, 0, "R2");

    // random mixture against the model
    na[0] = 32'h2_0000; na[1] = 32'h3_0000;
    for (int it = 0; it < 3000; it++) begin
      int k;
      int r;
      logic [31:0] pcn, pca, st;
      logic [4:0] dn;
      k = $urandom_range(0, 1);
      pcn = k ? 32'h244 : 32'h100;
      pca = k ? 32'h24C : 32'h108;
      dn = k ? 5'd6 : 5'd2;
      st = k ? 32'd8 : 32'd4;
      r = $urandom_range(0, 99);
      na[k] = na[k] + ((r < 4) ? 3 * st : st);
      nd[k] = $urandom_range(0, 255);
      issue(pcn, na[k], dn, 5'd1, 0, nd[k], "R6");
      if ($urandom_range(0, 9) < 8)
        issue(pca, 32'h8000 + nd[k] + (($urandom_range(0, 9) == 0) ? 1 : 0),
              5'd10 + 5'(k), dn, 32'h8000, $urandom, "R5");
      r = $urandom_range(0, 99);
      if (r < 4)
        issue(32'h400 + {$urandom_range(0, 63), 2'b00}, $urandom, 5'($urandom_range(0, 15)),
              5'($urandom_range(0, 15)), $urandom, $urandom, "R7");
      else if (r < 8)
        idle();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule